// File: doc/BRIEF.md
# Nibble-Prefix Instruction Decoder

This block turns a stream of single-byte instructions into decoded operations. The upper four bits of each byte pick one of sixteen primary functions, and the lower four bits carry a data nibble. Two of the primary functions are prefixes, one positive and one negative. A prefix adds its nibble to an internal operand register and produces no operation. This lets a program build an operand of any width up to the configured size, four bits at a time.

Any other byte issues exactly one decoded operation. The operation carries the primary function and the assembled operand. The operand register is then cleared for the next instruction. One primary function, "operate", marks the operation as extended: the assembled operand becomes a secondary opcode, so the set of zero-operand operations is open-ended.

Bytes enter through a valid/ready handshake. Decoded operations leave from a registered output stage with their own valid/ready pair. Instruction fetch, execution and branch handling belong to neighbouring blocks.

Top module: `nibdec_top`

## Requirements
- R1: Bits [7:4] of an accepted byte are the primary function code and bits [3:0] are its data nibble. Code 0x2 is the positive prefix, code 0x6 is the negative prefix and code 0xF is operate. The other codes are issued unchanged on `op_fn`.
- R2: A non-prefix byte with no prefix before it issues an operand equal to its nibble zero-extended. The operation is valid on `op_valid` in the cycle after the byte is accepted.
- R3: A positive prefix byte replaces the operand register with (register OR nibble) shifted left by 4.
- R4: A negative prefix byte replaces the operand register with the bitwise complement of (register OR nibble), shifted left by 4.
- R5: A non-prefix byte issues (register OR nibble) as `op_operand` and then clears the register to zero.
- R6: An issued operation has `op_is_sec` = 1 and `op_sec` equal to the low `SEC_W` bits of the operand when its function is 0xF. For any other function, `op_is_sec` = 0 and `op_sec` = 0.
- R7: A prefix byte never makes `op_valid` high in the following cycle. There is exactly one operation per non-prefix byte.
- R8: A byte is taken only on a cycle where both `in_valid` and `in_ready` are high. `in_ready` = !op_valid OR op_ready. While `op_valid` is high and `op_ready` is low, the issued operation stays stable. A byte presented with `in_valid` low has no effect.
- R9: Synchronous active-low reset clears `op_valid` and the operand register, including any partly built prefix chain.
- R10: Bits shifted past the top of the `OP_W`-bit operand register are lost. A chain longer than OP_W/4 nibbles keeps only the last OP_W/4 nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| op_valid | output | 1 | Decoded operation present |
| op_ready | input | 1 | Consumer takes the operation |
| op_fn | output | 4 | Primary function code |
| op_operand | output | OP_W | Assembled operand |
| op_is_sec | output | 1 | Operation is an extended (operate) operation |
| op_sec | output | SEC_W | Secondary opcode, low bits of the operand |

## Verification
The hardest states to reach from the ports are those where the operand register holds a long chain that mixes positive and negative prefixes. These include chains longer than the register can hold. No single byte shows the register's contents; they appear only in the operand of the next non-prefix byte. The stimulus therefore sends prefix runs of several lengths and sign mixes, each ended by a plain load whose expected operand is worked out by hand. A nine-nibble chain shows the truncation. A second awkward case is a prefix chain cut off by reset or by a stalled consumer. The bench holds `op_ready` low with a byte waiting, and asserts reset between a prefix and its final byte.

// File: rtl/nibdec_pkg.sv
// Package: shared types for the nibble-prefix decoder.
// Assumes: 4-bit primary function field, 4-bit data nibble.
package nibdec_pkg;

    localparam int FN_W  = 4;
    localparam int NIB_W = 4;

    // Primary function codes; prefix and operate codes are decoded by logic.
    typedef enum logic [FN_W-1:0] {
        FN_JUMP   = 4'h0,
        FN_LDLPTR = 4'h1,
        FN_PREPOS = 4'h2,
        FN_LDNLOC = 4'h3,
        FN_LDCON  = 4'h4,
        FN_LDNLPT = 4'h5,
        FN_PRENEG = 4'h6,
        FN_LDLOC  = 4'h7,
        FN_ADDCON = 4'h8,
        FN_CALL   = 4'h9,
        FN_CJUMP  = 4'hA,
        FN_ADJWS  = 4'hB,
        FN_EQCON  = 4'hC,
        FN_STLOC  = 4'hD,
        FN_STNLOC = 4'hE,
        FN_OPER   = 4'hF
    } fn_e;

    // First sixteen secondary opcodes carried by the operate function.
    typedef enum logic [3:0] {
        SEC_SWAP    = 4'h0,
        SEC_LDBYTE  = 4'h1,
        SEC_BYTESUB = 4'h2,
        SEC_ENDPROC = 4'h3,
        SEC_DIFF    = 4'h4,
        SEC_ADD     = 4'h5,
        SEC_GENCALL = 4'h6,
        SEC_CHIN    = 4'h7,
        SEC_PROD    = 4'h8,
        SEC_GT      = 4'h9,
        SEC_WORDSUB = 4'hA,
        SEC_CHOUT   = 4'hB,
        SEC_SUB     = 4'hC,
        SEC_STARTPR = 4'hD,
        SEC_OUTB    = 4'hE,
        SEC_OUTW    = 4'hF
    } sec_e;

endpackage

// File: rtl/nibdec_split.sv
// Module: nibdec_split
// Splits an instruction byte into function and nibble and classifies prefixes.
// Assumes: purely combinational; caller qualifies the result with its handshake.
module nibdec_split
    import nibdec_pkg::*;
(
    input  logic [7:0]       byte_in,
    output logic [FN_W-1:0]  fn,
    output logic [NIB_W-1:0] nib,
    output logic             is_pos,
    output logic             is_neg,
    output logic             is_prefix
);

    // Field extraction and prefix classification.
    always_comb begin
        fn        = byte_in[7:4];
        nib       = byte_in[3:0];
        is_pos    = (byte_in[7:4] == FN_PREPOS);
        is_neg    = (byte_in[7:4] == FN_PRENEG);
        is_prefix = is_pos | is_neg;
    end

endmodule

// File: rtl/nibdec_accum.sv
// Module: nibdec_accum
// Holds the operand register built up by prefix bytes.
// Assumes: OP_W is a multiple of 4 and at least 8; 'take' is one accepted byte.
module nibdec_accum
    import nibdec_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [NIB_W-1:0] nib,
    input  logic             is_pos,
    input  logic             is_neg,
    output logic [OP_W-1:0]  merged
);

    localparam int PAD_W = OP_W - NIB_W;

    logic [OP_W-1:0] acc_q;

    // Current register with the incoming nibble ORed into its low bits.
    always_comb begin
        merged = acc_q | {{PAD_W{1'b0}}, nib};
    end

    // Register update: shift for positive, complement and shift for negative, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (take) begin
            if (is_pos) begin
                acc_q <= merged << NIB_W;
            end else if (is_neg) begin
                acc_q <= (~merged) << NIB_W;
            end else begin
                acc_q <= '0;
            end
        end
    end

    // R5
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_pos && !is_neg) |=> (acc_q == '0));

    // R3
    pos_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_pos) |=> (acc_q[NIB_W-1:0] == '0));

    // R4
    neg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_neg) |=> (acc_q[OP_W-1:NIB_W] == ~($past(merged[OP_W-NIB_W-1:0]))));

endmodule

// File: rtl/nibdec_issue.sv
// Module: nibdec_issue
// Registered output stage for decoded operations with valid/ready.
// Assumes: 'load' only when the stage is empty or being drained this cycle.
module nibdec_issue
    import nibdec_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [FN_W-1:0]  fn_in,
    input  logic [OP_W-1:0]  operand_in,
    input  logic             op_ready,
    output logic             op_valid,
    output logic [FN_W-1:0]  op_fn,
    output logic [OP_W-1:0]  op_operand,
    output logic             op_is_sec,
    output logic [SEC_W-1:0] op_sec
);

    logic ext_in;

    // Operate-function detect on the incoming operation.
    always_comb begin
        ext_in = (fn_in == FN_OPER);
    end

    // Valid flag: set on load, cleared when the consumer takes the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
        end else if (load) begin
            op_valid <= 1'b1;
        end else if (op_ready) begin
            op_valid <= 1'b0;
        end
    end

    // Payload capture on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_fn      <= '0;
            op_operand <= '0;
            op_is_sec  <= 1'b0;
            op_sec     <= '0;
        end else if (load) begin
            op_fn      <= fn_in;
            op_operand <= operand_in;
            op_is_sec  <= ext_in;
            op_sec     <= ext_in ? operand_in[SEC_W-1:0] : '0;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_fn) && $stable(op_operand)));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !op_valid);

endmodule

// File: rtl/nibdec_top.sv
// Module: nibdec_top
// Nibble-prefix instruction decoder: assembles operands from prefix bytes and
// issues one decoded operation per non-prefix byte.
// Assumes: OP_W multiple of 4, OP_W >= 8, SEC_W <= OP_W.
module nibdec_top
    import nibdec_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             op_valid,
    input  logic             op_ready,
    output logic [3:0]       op_fn,
    output logic [OP_W-1:0]  op_operand,
    output logic             op_is_sec,
    output logic [SEC_W-1:0] op_sec
);

    logic [FN_W-1:0]  fn;
    logic [NIB_W-1:0] nib;
    logic             is_pos;
    logic             is_neg;
    logic             is_prefix;
    logic             take;
    logic             issue;
    logic [OP_W-1:0]  merged;

    nibdec_split u_split (
        .byte_in   (in_byte),
        .fn        (fn),
        .nib       (nib),
        .is_pos    (is_pos),
        .is_neg    (is_neg),
        .is_prefix (is_prefix)
    );

    // Handshake: accept when output stage is free or draining.
    always_comb begin
        in_ready = !op_valid || op_ready;
        take     = in_valid && in_ready;
        issue    = take && !is_prefix;
    end

    nibdec_accum #(.OP_W(OP_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .nib    (nib),
        .is_pos (is_pos),
        .is_neg (is_neg),
        .merged (merged)
    );

    nibdec_issue #(.OP_W(OP_W), .SEC_W(SEC_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (issue),
        .fn_in      (fn),
        .operand_in (merged),
        .op_ready   (op_ready),
        .op_valid   (op_valid),
        .op_fn      (op_fn),
        .op_operand (op_operand),
        .op_is_sec  (op_is_sec),
        .op_sec     (op_sec)
    );

    // R7
    prefix_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_byte[7:4] == 4'h2 || in_byte[7:4] == 4'h6)) |=> !op_valid);

    // R2
    issue_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_byte[7:4] != 4'h2 && in_byte[7:4] != 4'h6)
            |=> (op_valid && op_fn == $past(in_byte[7:4])));

    // R6
    sec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_byte[7:4] == 4'hF) |=> op_is_sec);

endmodule

// File: tb/sim_nibdec_top.sv
module sim_nibdec_top;

    localparam int OP_W  = 32;
    localparam int SEC_W = 8;
    localparam int NV    = 17;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = 8'h00;
    logic             in_ready;
    logic             op_valid;
    logic             op_ready = 1'b1;
    logic [3:0]       op_fn;
    logic [OP_W-1:0]  op_operand;
    logic             op_is_sec;
    logic [SEC_W-1:0] op_sec;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    nibdec_top #(.OP_W(OP_W), .SEC_W(SEC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .op_valid(op_valid), .op_ready(op_ready),
        .op_fn(op_fn), .op_operand(op_operand), .op_is_sec(op_is_sec), .op_sec(op_sec)
    );

    // Vector: {byte[44:37], expect_valid[36], fn[35:32], operand[31:0]}
    localparam logic [44:0] VEC [NV] = '{
        {8'h43, 1'b1, 4'h4, 32'h0000_0003},  // R2 plain load
        {8'h21, 1'b0, 4'h0, 32'h0000_0000},  // R3 prefix
        {8'h42, 1'b1, 4'h4, 32'h0000_0012},  // R3 R5
        {8'h60, 1'b0, 4'h0, 32'h0000_0000},  // R4
        {8'h4F, 1'b1, 4'h4, 32'hFFFF_FFFF},  // R4 -> -1
        {8'h60, 1'b0, 4'h0, 32'h0000_0000},
        {8'h40, 1'b1, 4'h4, 32'hFFFF_FFF0},  // R4 -> -16
        {8'hF5, 1'b1, 4'hF, 32'h0000_0005},  // R6 operate, add
        {8'h25, 1'b0, 4'h0, 32'h0000_0000},
        {8'hF1, 1'b1, 4'hF, 32'h0000_0051},  // R6 extended code 0x51
        {8'h21, 1'b0, 4'h0, 32'h0000_0000},
        {8'h60, 1'b0, 4'h0, 32'h0000_0000},  // R4 after R3
        {8'h45, 1'b1, 4'h4, 32'hFFFF_FEF5},
        {8'h0A, 1'b1, 4'h0, 32'h0000_000A},  // R1 function 0
        {8'h9C, 1'b1, 4'h9, 32'h0000_000C},  // R1 function 9
        {8'h64, 1'b0, 4'h0, 32'h0000_0000},
        {8'hB7, 1'b1, 4'hB, 32'hFFFF_FFB7}   // R4 R5
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        in_byte  = b;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000 && !finished) begin
            failures++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", cycles, 5000);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R9 reset state
        check(op_valid == 1'b0, "R9 op_valid in reset", 32'(op_valid), 32'd0);
        check(in_ready == 1'b1, "R8 in_ready in reset", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk with consumer always ready
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  b;
            logic        ev;
            logic [3:0]  ef;
            logic [31:0] eo;
            {b, ev, ef, eo} = VEC[i];
            send(b);
            check(op_valid == ev, "R7 op_valid per byte", 32'(op_valid), 32'(ev));
            if (ev) begin
                check(op_fn == ef, "R1 op_fn", 32'(op_fn), 32'(ef));
                check(op_operand == eo, "R5 op_operand", op_operand, eo);
                check(op_is_sec == (ef == 4'hF), "R6 op_is_sec", 32'(op_is_sec), 32'(ef == 4'hF));
                check(op_sec == ((ef == 4'hF) ? eo[7:0] : 8'h00), "R6 op_sec",
                      32'(op_sec), 32'((ef == 4'hF) ? eo[7:0] : 8'h00));
            end
        end

        // R10 nine-nibble chain keeps only the last eight
        for (int k = 1; k <= 8; k++) send(8'h20 | 8'(k));
        send(8'h49);
        check(op_operand == 32'h2345_6789, "R10 truncation", op_operand, 32'h2345_6789);

        // R8 backpressure: hold output, refuse input
        send(8'h47);
        op_ready = 1'b0;
        #1;
        check(in_ready == 1'b0, "R8 in_ready low when stalled", 32'(in_ready), 32'd0);
        in_byte  = 8'h41;
        in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check(op_valid == 1'b1, "R8 held valid", 32'(op_valid), 32'd1);
        check(op_operand == 32'd7, "R8 held operand", op_operand, 32'd7);
        op_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check(op_operand == 32'd1, "R8 taken after release", op_operand, 32'd1);
        @(posedge clk); @(negedge clk);
        check(op_valid == 1'b0, "R8 drained", 32'(op_valid), 32'd0);

        // R8 byte with in_valid low is ignored
        in_byte = 8'h2F;
        @(posedge clk); @(negedge clk);
        check(op_valid == 1'b0, "R8 ignored byte no op", 32'(op_valid), 32'd0);
        send(8'h41);
        check(op_operand == 32'd1, "R8 ignored byte no prefix", op_operand, 32'd1);

        // R9 reset mid-chain clears the operand register
        send(8'h23);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(op_valid == 1'b0, "R9 reset clears valid", 32'(op_valid), 32'd0);
        rst_n = 1'b1;
        send(8'h42);
        check(op_operand == 32'd2, "R9 prefix chain dropped", op_operand, 32'd2);
        check(op_fn == 4'h4, "R1 fn after reset", 32'(op_fn), 32'd4);

        finish_run();
    end

endmodule